// File: doc/BRIEF.md
# Dual-Clock FIFO with Handshaked Count Exchange

This block is a first-in first-out buffer whose writer and reader run on unrelated clocks. No read or write pointer ever crosses between the two clock domains. Each side keeps its own cautious count instead. The write side counts the free slots it may still fill. The read side counts the words it may still take.

Each side totals the operations it performs. It sends that total to the other side as a single count, carried by a toggle request and returned by a toggle acknowledge. The count register stays frozen while a transfer is open. Operations that happen during a transfer are added to the next one.

A slower or longer handshake costs nothing in correctness. It only delays the moment when the full flag or the empty flag is released. The block is used as a plain clock-crossing buffer. A producer writes while full is low. A consumer pops while empty is low and receives each word one read-clock cycle later.

Top module: `credfifo`

## Requirements
- R1: While either reset is asserted (active low, asynchronous), full is 0, empty is 1 and rdValid is 0.
- R2: Words come out on rdData in the order they were accepted, with their value unchanged, across any mix of write and read rates.
- R3: After DEPTH accepted writes with no pops, full is 1 from the write-clock cycle after the last accepted write. A write offered while full is 1 is dropped and never appears on the read port.
- R4: Empty is 1 whenever the read side knows of no stored word. A pop (rdEn high) while empty is 1 is ignored, and rdValid stays 0 in the next cycle.
- R5: A pop accepted at a read-clock edge (rdEn high, empty 0) sets rdValid to 1 with the word on rdData for exactly the following cycle. With no accepted pop, rdValid is 0.
- R6: Written words become visible to the reader, and freed slots become visible to the writer, within a bounded number of cycles once the handshake completes. Both flags release without any further traffic.
- R7: The views stay conservative. The writer never holds more than DEPTH unread words, and neither side's internal count ever exceeds DEPTH.
- R8: Operations that occur while a transfer is open are carried by a later transfer and never lost. After any traffic has settled, exactly DEPTH writes are again accepted before full rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| wrRst_n | input | 1 | Write-side asynchronous reset, active low |
| wrData | input | DATA_W | Word to store |
| wrValid | input | 1 | Offer wrData this cycle |
| full | output | 1 | No free slot known to the writer |
| rdClk | input | 1 | Read-side clock |
| rdRst_n | input | 1 | Read-side asynchronous reset, active low |
| rdEn | input | 1 | Pop request |
| rdData | output | DATA_W | Popped word |
| rdValid | output | 1 | rdData holds a popped word |
| empty | output | 1 | No stored word known to the reader |

## Verification
The bench first fills the buffer with no reads. This tells the full flag and the dropped write apart from a merely slow handshake. It then drains the buffer and pops once more while empty, which separates the empty guard from the data path. A long concurrent run with writer and reader gaps that vary out of step forces operations to pile up during open transfers. This run exposes lost or doubled counts as missing, extra or reordered words. A final refill that counts the writes accepted before full rises shows whether every freed slot was returned exactly once.

// File: rtl/credfifo_pkg.sv
package credfifo_pkg;
  // Strobes from control to datapath; push is in the write domain, pop in the read domain.
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrb_t;
endpackage

// File: rtl/credfifo_sync.sv
module credfifo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/credfifo_xfer.sv
// Moves an accumulated event count from one clock domain to another
// with a toggle request and a toggle acknowledge.
module credfifo_xfer #(
  parameter int CNT_W = 4
) (
  input  logic             srcClk,
  input  logic             srcRst_n,
  input  logic             srcEvent,
  input  logic             dstClk,
  input  logic             dstRst_n,
  output logic             dstLoad,
  output logic [CNT_W-1:0] dstCount
);
  logic [CNT_W-1:0] accCnt;
  logic [CNT_W-1:0] holdCnt;
  logic             reqTgl;
  logic             ackSync;
  logic             reqSync;
  logic             reqSeen;
  logic             srcIdle;
  logic             startXfer;

  assign srcIdle   = (reqTgl == ackSync);
  assign startXfer = srcIdle && (accCnt != '0);

  // Source side: hold register is frozen from request until acknowledge.
  always_ff @(posedge srcClk or negedge srcRst_n) begin
    if (!srcRst_n) begin
      accCnt  <= '0;
      holdCnt <= '0;
      reqTgl  <= 1'b0;
    end else if (startXfer) begin
      holdCnt <= accCnt;
      reqTgl  <= ~reqTgl;
      accCnt  <= CNT_W'(srcEvent);
    end else begin
      accCnt  <= accCnt + CNT_W'(srcEvent);
    end
  end

  credfifo_sync #(.STAGES(2)) u_reqSync (
    .clk  (dstClk),
    .rst_n(dstRst_n),
    .d    (reqTgl),
    .q    (reqSync)
  );

  // Destination side: take the count once per toggle, echo the toggle back.
  always_ff @(posedge dstClk or negedge dstRst_n) begin
    if (!dstRst_n) reqSeen <= 1'b0;
    else           reqSeen <= reqSync;
  end

  assign dstLoad  = reqSync ^ reqSeen;
  assign dstCount = holdCnt;

  credfifo_sync #(.STAGES(2)) u_ackSync (
    .clk  (srcClk),
    .rst_n(srcRst_n),
    .d    (reqSeen),
    .q    (ackSync)
  );
endmodule

// File: rtl/credfifo_ctrl.sv
module credfifo_ctrl
  import credfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             wrClk,
  input  logic             wrRst_n,
  input  logic             wrValid,
  input  logic             rdClk,
  input  logic             rdRst_n,
  input  logic             rdEn,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] freeCnt,
  output logic [CNT_W-1:0] availCnt,
  output fifoStrb_t        strb
);
  logic             enqLoad;
  logic [CNT_W-1:0] enqCount;
  logic             deqLoad;
  logic [CNT_W-1:0] deqCount;

  assign full      = (freeCnt == '0);
  assign empty     = (availCnt == '0);
  assign strb.push = wrValid && !full;
  assign strb.pop  = rdEn && !empty;

  // Enqueued counts travel write -> read.
  credfifo_xfer #(.CNT_W(CNT_W)) u_enqXfer (
    .srcClk  (wrClk),
    .srcRst_n(wrRst_n),
    .srcEvent(strb.push),
    .dstClk  (rdClk),
    .dstRst_n(rdRst_n),
    .dstLoad (enqLoad),
    .dstCount(enqCount)
  );

  // Dequeued counts travel read -> write.
  credfifo_xfer #(.CNT_W(CNT_W)) u_deqXfer (
    .srcClk  (rdClk),
    .srcRst_n(rdRst_n),
    .srcEvent(strb.pop),
    .dstClk  (wrClk),
    .dstRst_n(wrRst_n),
    .dstLoad (deqLoad),
    .dstCount(deqCount)
  );

  always_ff @(posedge wrClk or negedge wrRst_n) begin
    if (!wrRst_n) freeCnt <= CNT_W'(DEPTH);
    else freeCnt <= freeCnt - CNT_W'(strb.push) + (deqLoad ? deqCount : '0);
  end

  always_ff @(posedge rdClk or negedge rdRst_n) begin
    if (!rdRst_n) availCnt <= '0;
    else availCnt <= availCnt - CNT_W'(strb.pop) + (enqLoad ? enqCount : '0);
  end
endmodule

// File: rtl/credfifo_dpath.sv
module credfifo_dpath
  import credfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wrClk,
  input  logic              wrRst_n,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdRst_n,
  input  fifoStrb_t         strb,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] wrPtr
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdPtr;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge wrClk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge wrClk or negedge wrRst_n) begin
    if (!wrRst_n)       wrPtr <= '0;
    else if (strb.push) wrPtr <= nextPtr(wrPtr);
  end

  always_ff @(posedge rdClk or negedge rdRst_n) begin
    if (!rdRst_n) begin
      rdPtr   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.pop;
      if (strb.pop) begin
        rdData <= mem[rdPtr];
        rdPtr  <= nextPtr(rdPtr);
      end
    end
  end
endmodule

// File: rtl/credfifo.sv
module credfifo
  import credfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              wrClk,
  input  logic              wrRst_n,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  output logic              full,
  input  logic              rdClk,
  input  logic              rdRst_n,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              empty
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  fifoStrb_t        strb;
  logic [CNT_W-1:0] freeCnt;
  logic [CNT_W-1:0] availCnt;
  logic [ADDR_W-1:0] wrPtr;

  credfifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .wrClk   (wrClk),
    .wrRst_n (wrRst_n),
    .wrValid (wrValid),
    .rdClk   (rdClk),
    .rdRst_n (rdRst_n),
    .rdEn    (rdEn),
    .full    (full),
    .empty   (empty),
    .freeCnt (freeCnt),
    .availCnt(availCnt),
    .strb    (strb)
  );

  credfifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dpath (
    .wrClk  (wrClk),
    .wrRst_n(wrRst_n),
    .wrData (wrData),
    .rdClk  (rdClk),
    .rdRst_n(rdRst_n),
    .strb   (strb),
    .rdData (rdData),
    .rdValid(rdValid),
    .wrPtr  (wrPtr)
  );
endmodule

// File: rtl/credfifo_chk.sv
module credfifo_chk #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 3
) (
  input logic              wrClk,
  input logic              wrRst_n,
  input logic              wrValid,
  input logic              full,
  input logic [ADDR_W-1:0] wrPtr,
  input logic [CNT_W-1:0]  freeCnt,
  input logic              rdClk,
  input logic              rdRst_n,
  input logic              rdEn,
  input logic              empty,
  input logic              rdValid,
  input logic [CNT_W-1:0]  availCnt
);
  AST_FULL_DROPS: assert property (@(posedge wrClk) disable iff (!wrRst_n)
    (full && wrValid) |=> $stable(wrPtr)); // R3
  AST_PUSH_ADVANCES: assert property (@(posedge wrClk) disable iff (!wrRst_n)
    (wrValid && !full) |=> (wrPtr != $past(wrPtr))); // R2
  AST_EMPTY_NO_DATA: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    (empty && rdEn) |=> !rdValid); // R4
  AST_POP_VALID: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    (rdEn && !empty) |=> rdValid); // R5
  AST_IDLE_NO_VALID: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    !rdEn |=> !rdValid); // R5
  AST_FREE_BOUND: assert property (@(posedge wrClk) disable iff (!wrRst_n)
    freeCnt <= CNT_W'(DEPTH)); // R7
  AST_AVAIL_BOUND: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    availCnt <= CNT_W'(DEPTH)); // R7
endmodule

bind credfifo credfifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .wrClk   (wrClk),
  .wrRst_n (wrRst_n),
  .wrValid (wrValid),
  .full    (full),
  .wrPtr   (wrPtr),
  .freeCnt (freeCnt),
  .rdClk   (rdClk),
  .rdRst_n (rdRst_n),
  .rdEn    (rdEn),
  .empty   (empty),
  .rdValid (rdValid),
  .availCnt(availCnt)
);

// File: tb/sim_credfifo.sv
module sim_credfifo;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int NSTREAM = 80;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  always #5 wrClk = ~wrClk;
  always #7 rdClk = ~rdClk;

  logic          wrRst_n, rdRst_n;
  logic [DW-1:0] wrData;
  logic          wrValid, full;
  logic          rdEn, rdValid, empty;
  logic [DW-1:0] rdData;

  credfifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .wrClk(wrClk), .wrRst_n(wrRst_n), .wrData(wrData), .wrValid(wrValid), .full(full),
    .rdClk(rdClk), .rdRst_n(rdRst_n), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .empty(empty)
  );

  int checks = 0;
  int errors = 0;
  int accepted = 0;
  int popped = 0;
  int received = 0;
  int maxOcc = 0;
  logic [DW-1:0] expQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushWord(input logic [DW-1:0] d);
    @(negedge wrClk);
    while (full) @(negedge wrClk);
    wrData  = d;
    wrValid = 1'b1;
    @(negedge wrClk);
    wrValid = 1'b0;
    expQ.push_back(d);
    accepted++;
    if (accepted - popped > maxOcc) maxOcc = accepted - popped;
  endtask

  task automatic popOne();
    @(negedge rdClk);
    while (empty) @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    popped++;
  endtask

  // Scoreboard monitor
  always @(negedge rdClk) begin
    if (rdValid) begin
      received++;
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "word with none expected", int'(rdData), -1);
      end else begin
        logic [DW-1:0] exp;
        exp = expQ.pop_front();
        check(rdData == exp, "R2", "data order", int'(rdData), int'(exp));
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge wrClk);
    errors++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", received, DEPTH * 2 + NSTREAM);
    summary();
    $finish;
  end

  initial begin
    wrRst_n = 1'b0; rdRst_n = 1'b0;
    wrValid = 1'b0; rdEn = 1'b0; wrData = '0;
    repeat (3) @(negedge wrClk);
    check(full == 1'b0, "R1", "full in reset", int'(full), 0);
    check(empty == 1'b1, "R1", "empty in reset", int'(empty), 1);
    check(rdValid == 1'b0, "R1", "rdValid in reset", int'(rdValid), 0);
    @(negedge wrClk); wrRst_n = 1'b1;
    @(negedge rdClk); rdRst_n = 1'b1;

    // Fill with no reads (R3)
    for (int i = 0; i < DEPTH; i++) pushWord(DW'(8'h10 + i));
    check(full == 1'b1, "R3", "full after DEPTH writes", int'(full), 1);
    @(negedge wrClk);
    wrData = 8'hEE; wrValid = 1'b1;
    @(negedge wrClk);
    wrValid = 1'b0;
    check(full == 1'b1, "R3", "full after dropped write", int'(full), 1);

    // Handshake delivers the stored words (R6)
    repeat (30) @(negedge rdClk);
    check(empty == 1'b0, "R6", "empty released", int'(empty), 0);

    // Drain (R2, R5, R4)
    for (int i = 0; i < DEPTH; i++) popOne();
    @(negedge rdClk);
    check(rdValid == 1'b0, "R5", "rdValid one cycle", int'(rdValid), 0);
    check(empty == 1'b1, "R4", "empty after drain", int'(empty), 1);
    check(received == DEPTH, "R2", "words received", received, DEPTH);
    check(expQ.size() == 0, "R3", "dropped word absent", expQ.size(), 0);

    // Pop while empty (R4)
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
    check(rdValid == 1'b0, "R4", "pop on empty ignored", int'(rdValid), 0);

    repeat (30) @(negedge wrClk);
    check(full == 1'b0, "R6", "full released", int'(full), 0);

    // Concurrent stream with uneven gaps (R2, R7, R8)
    fork
      begin
        for (int i = 0; i < NSTREAM; i++) begin
          pushWord(DW'(i * 7 + 3));
          repeat (i % 4) @(negedge wrClk);
        end
      end
      begin
        for (int i = 0; i < NSTREAM; i++) begin
          popOne();
          repeat ((i * 5) % 3) @(negedge rdClk);
        end
      end
    join
    repeat (10) @(negedge rdClk);
    check(received == DEPTH + NSTREAM, "R7", "stream words received", received, DEPTH + NSTREAM);
    check(maxOcc <= DEPTH, "R7", "occupancy bound", maxOcc, DEPTH);
    check(empty == 1'b1, "R4", "empty after stream", int'(empty), 1);

    // Exactly DEPTH slots returned (R8)
    repeat (30) @(negedge wrClk);
    for (int i = 0; i < DEPTH - 1; i++) pushWord(DW'(8'hA0 + i));
    check(full == 1'b0, "R8", "not full at DEPTH-1", int'(full), 0);
    pushWord(DW'(8'hA0 + DEPTH - 1));
    check(full == 1'b1, "R8", "full at DEPTH", int'(full), 1);
    repeat (30) @(negedge rdClk);
    for (int i = 0; i < DEPTH; i++) popOne();
    repeat (5) @(negedge rdClk);
    check(received == 2 * DEPTH + NSTREAM, "R2", "final words received",
          received, 2 * DEPTH + NSTREAM);

    summary();
    $finish;
  end
endmodule